// File: doc/BRIEF.md
# Retained Key Vault Controller

The block is a register-mapped controller for a 288-bit secret held as nine 32-bit words in retained storage. Reset does not clear these words. A host reaches the block over a 32-bit word-only request/response bus. The host cannot read the secret back. It can only load it, wipe it, and ask the block to check it against an expected checksum.

Loading needs an unlock step. The host writes one fixed 32-bit code to a command register. This wipes the key and enters a programming state that only reset can leave. The most significant word follows one of two policies, chosen by a configuration input:
- **Hidden:** the word is write-only and is wiped with the rest of the key.
- **Visible:** the word can be read back, survives a wipe, and can be frozen by a set-only lock.

An integrity command runs a serial checksum over the lower eight words. It then reports done and pass flags. One maskable interrupt reports bus errors on unmapped offsets.

Top module: `keyvault_ctrl`

## Requirements
- R1: After reset the status word reads 0, the mask register reads 1, the interrupt status, lock and bus-error-enable registers read 0, `irq` is low and `req_ready` is high.
- R2: Writing 0x757BDF0D to offset 0x08 wipes the key and sets status bit 0 (programming), which stays set until reset. Any other value written there changes nothing.
- R3: Writes to key words 0..7 (offsets 0x10..0x2C) are dropped while status bit 0 is clear. Reads of offsets 0x04, 0x08, 0x0C, 0x10..0x2C, 0x40 and 0x44 always return 0.
- R4: Writing a 1 in bit 0 of offset 0x04 wipes key words 0..7 and sets status bit 4 (wiped). The bit reads back as 0.
- R5: An accepted nonzero write to key words 0..7 clears status bit 4. A nonzero write to word 8 clears it only under the hidden policy. A zero write never clears it.
- R6: With `cfg_w8_hidden` high, word 8 (offset 0x30) reads as 0, is cleared by a wipe, and the lock at offset 0x4C never sets. With it low, word 8 reads back its value and a wipe leaves it intact.
- R7: Word 8 accepts a write only while status bit 0 is set and the lock is clear. Writing bit 0 of 0x4C sets the lock, and only reset clears it.
- R8: In programming state, a write to 0x0C drops `req_ready` for 9 cycles (10 under the hidden policy, which prepends a zero word). The block then sets status bit 8 (done) and sets status bit 9 (pass) exactly when the written value equals the reflected CRC-32 of words 0..7. That CRC uses polynomial 0x82F63B78, initial value 0 and no final inversion. Outside programming state the write has no effect.
- R9: Interrupt status bit 0 (offset 0x38) clears when a 1 is written to it. A 1 written to 0x40 clears mask bit 0, and a 1 written to 0x44 sets it. The mask at 0x3C ignores direct writes. `irq` is high exactly when the status bit is set and the mask bit is clear.
- R10: When bit 0 of 0x34 is set, any access to an unmapped or misaligned offset (for example 0x48, 0x02, 0xFC) returns `rsp_err` and sets interrupt status bit 0. When that bit is clear, such an access reads 0 with no error.
- R11: Reset leaves the key words unchanged; a visible word 8 reads the same value before and after reset.
- R12: Every accepted request (`req_valid` and `req_ready`) produces `rsp_valid` for exactly one cycle, in the cycle that follows. Writes return `rsp_rdata` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears all control and status state but not the key words |
| cfg_w8_hidden | input | 1 | Word 8 policy: 1 = write-only, wiped with the key, lock disabled, zero word prepended to the checksum |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request; low while a checksum runs |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the request accepted in the previous cycle |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Error response for an unmapped offset when bus errors are enabled |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that `cfg_w8_hidden` changes only while reset is held. They also assume a request is seen as accepted only in a cycle where `req_ready` is high. The stimulus follows both rules: it changes the policy input only inside a reset pulse, and it waits for `req_ready` before it raises `req_valid` for one cycle. Under these conditions the stickiness of the programming and lock flags, the disabled lock under the hidden policy, and the link between error responses and the interrupt flag can be checked cycle by cycle.

// File: rtl/keyvault_pkg.sv
package keyvault_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned KEY_WORDS  = 9;
    localparam int unsigned KEY_IDX_W  = $clog2(KEY_WORDS);
    localparam int unsigned IRQ_W      = 1;

    localparam logic [DATA_W-1:0] UNLOCK_CODE = 32'h757B_DF0D;
    localparam logic [DATA_W-1:0] CRC_POLY    = 32'h82F6_3B78;

    // word indices of the register map (byte offset / 4)
    localparam int unsigned W_STATUS  = 0;
    localparam int unsigned W_CTRL    = 1;
    localparam int unsigned W_PGM     = 2;
    localparam int unsigned W_CRC     = 3;
    localparam int unsigned W_KEY0    = 4;
    localparam int unsigned W_BERR_EN = 13;
    localparam int unsigned W_ISR     = 14;
    localparam int unsigned W_IMR     = 15;
    localparam int unsigned W_IER     = 16;
    localparam int unsigned W_IDR     = 17;
    localparam int unsigned W_LOCK    = 19;

    // status word bit positions
    localparam int unsigned ST_PGM  = 0;
    localparam int unsigned ST_WIPE = 4;
    localparam int unsigned ST_DONE = 8;
    localparam int unsigned ST_PASS = 9;

    typedef enum logic [3:0] {
        SEL_STATUS,
        SEL_CTRL,
        SEL_PGM,
        SEL_CRC,
        SEL_KEY,
        SEL_BERR_EN,
        SEL_ISR,
        SEL_IMR,
        SEL_IER,
        SEL_IDR,
        SEL_LOCK,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e               sel;
        logic [KEY_IDX_W-1:0]   key_idx;
    } decode_t;

    // One 32-bit word folded into a reflected CRC, low bit first.
    function automatic logic [DATA_W-1:0] crc_fold(input logic [DATA_W-1:0] crc,
                                                   input logic [DATA_W-1:0] word);
        logic [DATA_W-1:0] c;
        c = crc ^ word;
        for (int i = 0; i < DATA_W; i++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/keyvault_decode.sv
module keyvault_decode
    import keyvault_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    localparam int unsigned WI_W = ADDR_W - 2;

    logic [WI_W-1:0] widx;
    int unsigned     wi;

    always_comb begin
        widx        = addr[ADDR_W-1:2];
        wi          = 32'(widx);
        dec.sel     = SEL_NONE;
        dec.key_idx = '0;
        if (addr[1:0] == 2'b00) begin
            case (wi)
                W_STATUS:  dec.sel = SEL_STATUS;
                W_CTRL:    dec.sel = SEL_CTRL;
                W_PGM:     dec.sel = SEL_PGM;
                W_CRC:     dec.sel = SEL_CRC;
                W_BERR_EN: dec.sel = SEL_BERR_EN;
                W_ISR:     dec.sel = SEL_ISR;
                W_IMR:     dec.sel = SEL_IMR;
                W_IER:     dec.sel = SEL_IER;
                W_IDR:     dec.sel = SEL_IDR;
                W_LOCK:    dec.sel = SEL_LOCK;
                default: begin
                    if (wi >= W_KEY0 && wi < W_KEY0 + KEY_WORDS) begin
                        dec.sel     = SEL_KEY;
                        dec.key_idx = KEY_IDX_W'(wi - W_KEY0);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/keyvault_store.sv
module keyvault_store
    import keyvault_pkg::*;
#(
    parameter int unsigned WORDS  = KEY_WORDS,
    parameter int unsigned WIDTH  = DATA_W,
    localparam int unsigned IDX_W = $clog2(WORDS)
) (
    input  logic                         clk,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [WIDTH-1:0]             wr_data,
    input  logic                         pgm_mode,
    input  logic                         top_locked,
    input  logic                         top_hidden,
    input  logic                         wipe,
    output logic [WORDS-1:0][WIDTH-1:0]  words,
    output logic                         wipe_flag_clr
);
    logic [WORDS-1:0] hit;
    logic [WORDS-1:0] clr;
    logic [WORDS-1:0] counts;
    logic [WORDS-1:0][WIDTH-1:0] words_q;

    for (genvar g = 0; g < WORDS; g++) begin : g_slot
        if (g == WORDS - 1) begin : g_top
            assign hit[g]    = wr_en && (wr_idx == IDX_W'(g)) && pgm_mode && !top_locked;
            assign clr[g]    = wipe && top_hidden;
            assign counts[g] = top_hidden;
        end else begin : g_low
            assign hit[g]    = wr_en && (wr_idx == IDX_W'(g)) && pgm_mode;
            assign clr[g]    = wipe;
            assign counts[g] = 1'b1;
        end
    end

    // Retained storage: deliberately outside the reset domain.
    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (clr[i]) begin
                words_q[i] <= '0;
            end else if (hit[i]) begin
                words_q[i] <= wr_data;
            end
        end
    end

    assign words         = words_q;
    assign wipe_flag_clr = (wr_data != '0) && |(hit & counts);
endmodule

// File: rtl/keyvault_crc.sv
module keyvault_crc
    import keyvault_pkg::*;
#(
    parameter int unsigned NW    = KEY_WORDS - 1,
    localparam int unsigned PW   = $clog2(NW)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic                        pad,
    input  logic [NW-1:0][DATA_W-1:0]   words,
    output logic                        busy,
    output logic                        fin,
    output logic [DATA_W-1:0]           result
);
    logic              run_q;
    logic              pad_q;
    logic              fin_q;
    logic [PW-1:0]     ptr_q;
    logic [DATA_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            pad_q <= 1'b0;
            fin_q <= 1'b0;
            ptr_q <= '0;
            acc_q <= '0;
        end else begin
            fin_q <= 1'b0;
            if (start) begin
                run_q <= 1'b1;
                pad_q <= pad;
                ptr_q <= '0;
                acc_q <= '0;
            end else if (run_q) begin
                if (pad_q) begin
                    acc_q <= crc_fold(acc_q, '0);
                    pad_q <= 1'b0;
                end else begin
                    acc_q <= crc_fold(acc_q, words[ptr_q]);
                    if (ptr_q == PW'(NW - 1)) begin
                        run_q <= 1'b0;
                        fin_q <= 1'b1;
                    end else begin
                        ptr_q <= ptr_q + 1'b1;
                    end
                end
            end
        end
    end

    assign busy   = run_q | fin_q;
    assign fin    = fin_q;
    assign result = acc_q;
endmodule

// File: rtl/keyvault_irq.sv
module keyvault_irq #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raise,
    input  logic         isr_wr,
    input  logic         ier_wr,
    input  logic         idr_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] isr,
    output logic [W-1:0] imr,
    output logic         irq
);
    logic [W-1:0] isr_q;
    logic [W-1:0] imr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q <= '0;
            imr_q <= '1;
        end else begin
            isr_q <= (isr_q & ~(isr_wr ? wdata : '0)) | raise;
            if (ier_wr) begin
                imr_q <= imr_q & ~wdata;
            end else if (idr_wr) begin
                imr_q <= imr_q | wdata;
            end
        end
    end

    assign isr = isr_q;
    assign imr = imr_q;
    assign irq = |(isr_q & ~imr_q);
endmodule

// File: rtl/keyvault_ctrl.sv
module keyvault_ctrl
    import keyvault_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_w8_hidden,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              irq
);
    localparam int unsigned LOW_WORDS = KEY_WORDS - 1;

    decode_t dec;
    logic    take, wr, rd;
    logic    pgm_q, wipe_q, done_q, pass_q, lock_q, berr_en_q;
    logic [DATA_W-1:0] crc_exp_q;
    logic    wipe_now, unlock_now, crc_start, wipe_flag_clr, berr_hit;
    logic    crc_busy, crc_fin;
    logic [DATA_W-1:0] crc_val;
    logic [KEY_WORDS-1:0][DATA_W-1:0] key_words;
    logic [IRQ_W-1:0] isr_q, imr_q;
    logic [DATA_W-1:0] status_w, rd_mux;
    logic    rsp_valid_q, rsp_err_q;
    logic [DATA_W-1:0] rsp_rdata_q;

    keyvault_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (req_addr),
        .dec  (dec)
    );

    assign req_ready  = !crc_busy;
    assign take       = req_valid && req_ready;
    assign wr         = take && req_write;
    assign rd         = take && !req_write;
    assign unlock_now = wr && (dec.sel == SEL_PGM) && (req_wdata == UNLOCK_CODE);
    assign wipe_now   = unlock_now || (wr && (dec.sel == SEL_CTRL) && req_wdata[0]);
    assign crc_start  = wr && (dec.sel == SEL_CRC) && pgm_q;
    assign berr_hit   = take && (dec.sel == SEL_NONE) && berr_en_q;

    keyvault_store #(.WORDS(KEY_WORDS), .WIDTH(DATA_W)) u_store (
        .clk           (clk),
        .wr_en         (wr && (dec.sel == SEL_KEY)),
        .wr_idx        (dec.key_idx),
        .wr_data       (req_wdata),
        .pgm_mode      (pgm_q),
        .top_locked    (lock_q),
        .top_hidden    (cfg_w8_hidden),
        .wipe          (wipe_now),
        .words         (key_words),
        .wipe_flag_clr (wipe_flag_clr)
    );

    keyvault_crc #(.NW(LOW_WORDS)) u_crc (
        .clk    (clk),
        .rst    (rst),
        .start  (crc_start),
        .pad    (cfg_w8_hidden),
        .words  (key_words[LOW_WORDS-1:0]),
        .busy   (crc_busy),
        .fin    (crc_fin),
        .result (crc_val)
    );

    keyvault_irq #(.W(IRQ_W)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .raise  (IRQ_W'(berr_hit)),
        .isr_wr (wr && (dec.sel == SEL_ISR)),
        .ier_wr (wr && (dec.sel == SEL_IER)),
        .idr_wr (wr && (dec.sel == SEL_IDR)),
        .wdata  (req_wdata[IRQ_W-1:0]),
        .isr    (isr_q),
        .imr    (imr_q),
        .irq    (irq)
    );

    // control and status state
    always_ff @(posedge clk) begin
        if (rst) begin
            pgm_q     <= 1'b0;
            wipe_q    <= 1'b0;
            done_q    <= 1'b0;
            pass_q    <= 1'b0;
            lock_q    <= 1'b0;
            berr_en_q <= 1'b0;
            crc_exp_q <= '0;
        end else begin
            if (unlock_now) begin
                pgm_q <= 1'b1;
            end
            if (wipe_now) begin
                wipe_q <= 1'b1;
            end else if (wipe_flag_clr) begin
                wipe_q <= 1'b0;
            end
            if (crc_start) begin
                crc_exp_q <= req_wdata;
            end
            if (crc_fin) begin
                done_q <= 1'b1;
                pass_q <= (crc_val == crc_exp_q);
            end
            if (wr && (dec.sel == SEL_LOCK) && req_wdata[0] && !cfg_w8_hidden) begin
                lock_q <= 1'b1;
            end
            if (wr && (dec.sel == SEL_BERR_EN)) begin
                berr_en_q <= req_wdata[0];
            end
        end
    end

    always_comb begin
        status_w          = '0;
        status_w[ST_PGM]  = pgm_q;
        status_w[ST_WIPE] = wipe_q;
        status_w[ST_DONE] = done_q;
        status_w[ST_PASS] = pass_q;
    end

    always_comb begin
        rd_mux = '0;
        case (dec.sel)
            SEL_STATUS:  rd_mux = status_w;
            SEL_KEY: begin
                if ((dec.key_idx == KEY_IDX_W'(KEY_WORDS - 1)) && !cfg_w8_hidden) begin
                    rd_mux = key_words[KEY_WORDS-1];
                end
            end
            SEL_BERR_EN: rd_mux[0] = berr_en_q;
            SEL_ISR:     rd_mux[IRQ_W-1:0] = isr_q;
            SEL_IMR:     rd_mux[IRQ_W-1:0] = imr_q;
            SEL_LOCK:    rd_mux[0] = lock_q;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= take;
            rsp_err_q   <= berr_hit;
            rsp_rdata_q <= rd ? rd_mux : '0;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_err   = rsp_err_q;
    assign rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/keyvault_chk.sv
module keyvault_chk #(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_w8_hidden,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              wdata0,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              irq,
    input logic              pgm_q,
    input logic              lock_q,
    input logic              wipe_q,
    input logic              done_q,
    input logic              isr0,
    input logic              imr0
);
    AST_UNLOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        pgm_q |=> pgm_q); // R2

    AST_CTRL_WIPE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write && req_addr == ADDR_W'(4) && wdata0) |=> wipe_q); // R4

    AST_LOCK_OFF_HIDDEN: assert property (@(posedge clk) disable iff (rst)
        (cfg_w8_hidden && !lock_q) |=> !lock_q); // R6

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> lock_q); // R7

    AST_DONE_NEEDS_PGM: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> pgm_q); // R8

    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
        imr0 |-> !irq); // R9

    AST_BERR_FLAG: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (isr0 && rsp_valid)); // R10

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && req_ready)); // R12
endmodule

bind keyvault_ctrl keyvault_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_w8_hidden (cfg_w8_hidden),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .wdata0        (req_wdata[0]),
    .rsp_valid     (rsp_valid),
    .rsp_err       (rsp_err),
    .irq           (irq),
    .pgm_q         (pgm_q),
    .lock_q        (lock_q),
    .wipe_q        (wipe_q),
    .done_q        (done_q),
    .isr0          (isr_q[0]),
    .imr0          (imr_q[0])
);

// File: tb/keyvault_ctrl_tb.sv
module keyvault_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MAGIC = 32'h757BDF0D;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_w8_hidden = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done_flag = 1'b0;

    // behavioural reference state
    bit          m_pgm, m_wipe, m_done, m_pass, m_lock, m_berr, m_isr, m_imr;
    logic [31:0] m_key [9];
    bit          m_k8_known = 1'b0;
    int          m_wait = 0;

    keyvault_ctrl #(.ADDR_W(8)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .cfg_w8_hidden (cfg_w8_hidden),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .rsp_err       (rsp_err),
        .irq           (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit is_unmapped(input logic [7:0] a);
        if (a[1:0] != 2'b00) return 1'b1;
        if (a == 8'h48) return 1'b1;
        return a > 8'h4C;
    endfunction

    function automatic logic [31:0] ref_crc();
        logic [31:0] c;
        c = '0;
        for (int w = (cfg_w8_hidden ? -1 : 0); w < 8; w++) begin
            for (int b = 0; b < 32; b++) begin
                logic din;
                logic fb;
                din = (w < 0) ? 1'b0 : m_key[w][b];
                fb  = c[0] ^ din;
                c   = c >> 1;
                if (fb) c = c ^ 32'h82F63B78;
            end
        end
        return c;
    endfunction

    function automatic logic [31:0] ref_read(input logic [7:0] a);
        logic [31:0] v;
        v = '0;
        case (a)
            8'h00: begin
                v[0] = m_pgm; v[4] = m_wipe; v[8] = m_done; v[9] = m_pass;
            end
            8'h30: v = cfg_w8_hidden ? 32'h0 : m_key[8];
            8'h34: v[0] = m_berr;
            8'h38: v[0] = m_isr;
            8'h3C: v[0] = m_imr;
            8'h4C: v[0] = m_lock;
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic ref_wipe();
        for (int i = 0; i < 8; i++) m_key[i] = '0;
        if (cfg_w8_hidden) begin
            m_key[8] = '0;
            m_k8_known = 1'b1;
        end
        m_wipe = 1'b1;
    endtask

    task automatic ref_update(input bit we, input logic [7:0] a, input logic [31:0] d);
        if (is_unmapped(a)) begin
            if (m_berr) m_isr = 1'b1;
        end else if (we) begin
            if (a == 8'h04 && d[0]) ref_wipe();
            if (a == 8'h08 && d == MAGIC) begin
                ref_wipe();
                m_pgm = 1'b1;
            end
            if (a == 8'h0C && m_pgm) begin
                m_wait = cfg_w8_hidden ? 10 : 9;
                m_done = 1'b1;
                m_pass = (d == ref_crc());
            end
            if (a >= 8'h10 && a <= 8'h2C && m_pgm) begin
                m_key[(a - 8'h10) >> 2] = d;
                if (d != 0) m_wipe = 1'b0;
            end
            if (a == 8'h30 && m_pgm && !m_lock) begin
                m_key[8] = d;
                m_k8_known = 1'b1;
                if (d != 0 && cfg_w8_hidden) m_wipe = 1'b0;
            end
            if (a == 8'h34) m_berr = d[0];
            if (a == 8'h38 && d[0]) m_isr = 1'b0;
            if (a == 8'h40 && d[0]) m_imr = 1'b0;
            if (a == 8'h44 && d[0]) m_imr = 1'b1;
            if (a == 8'h4C && d[0] && !cfg_w8_hidden) m_lock = 1'b1;
        end
    endtask

    // one bus access, checked against the reference
    task automatic access(input bit we, input logic [7:0] a, input logic [31:0] d,
                          input string tag);
        logic [31:0] exp_d;
        bit          exp_e;
        bit          chk_d;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exp_e = is_unmapped(a) && m_berr;
        exp_d = we ? 32'h0 : ref_read(a);
        chk_d = !(a == 8'h30 && !cfg_w8_hidden && !m_k8_known);
        req_valid = 1'b1;
        req_write = we;
        req_addr  = a;
        req_wdata = d;
        @(posedge clk);
        #1;
        ref_update(we, a, d);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b1, "R12", "rsp_valid", 32'(rsp_valid), 32'h1);
        check(rsp_err == exp_e, "R10", $sformatf("rsp_err @%h", a), 32'(rsp_err), 32'(exp_e));
        if (chk_d)
            check(rsp_rdata == exp_d, tag, $sformatf("rdata @%h", a), rsp_rdata, exp_d);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        access(1'b1, a, d, tag);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        access(1'b0, a, 32'h0, tag);
    endtask

    task automatic do_reset(input bit hidden);
        @(negedge clk);
        rst = 1'b1;
        cfg_w8_hidden = hidden;
        repeat (3) @(posedge clk);
        m_pgm = 0; m_wipe = 0; m_done = 0; m_pass = 0;
        m_lock = 0; m_berr = 0; m_isr = 0; m_imr = 1; m_wait = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // cycle-by-cycle comparison of ready and interrupt
    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            check(req_ready == (m_wait == 0), "R8", "req_ready", 32'(req_ready), 32'(m_wait == 0));
            check(irq == (m_isr && !m_imr), "R9", "irq", 32'(irq), 32'(m_isr && !m_imr));
            if (m_wait > 0) m_wait--;
        end
    end

    task automatic finish_run();
        done_flag = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        check(1'b0, "WDOG", "watchdog expired", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 9; i++) m_key[i] = '0;
        // ---------------- visible word-8 policy ----------------
        do_reset(1'b0);
        rd(8'h00, "R1"); rd(8'h3C, "R1"); rd(8'h38, "R1");
        rd(8'h4C, "R1"); rd(8'h34, "R1");
        // checksum command outside programming state does nothing (R8)
        wr(8'h0C, 32'h1234, "R8"); rd(8'h00, "R8");
        // wipe via control, then ignored key write keeps the wiped flag (R4, R3)
        wr(8'h04, 32'h1, "R4"); rd(8'h00, "R4"); rd(8'h04, "R4");
        wr(8'h10, 32'hDEAD_BEEF, "R3"); rd(8'h00, "R3");
        // wrong unlock value, then the real one (R2)
        wr(8'h08, 32'h757BDF0C, "R2"); rd(8'h00, "R2");
        wr(8'h08, MAGIC, "R2"); rd(8'h00, "R2"); rd(8'h08, "R2");
        // zero key write keeps the flag, nonzero clears it (R5)
        wr(8'h10, 32'h0, "R5"); rd(8'h00, "R5");
        for (int i = 0; i < 8; i++) wr(8'(8'h10 + 4 * i), 32'h0101_0101 * (i + 3), "R5");
        rd(8'h00, "R5");
        for (int i = 0; i < 8; i++) rd(8'(8'h10 + 4 * i), "R3");
        rd(8'h0C, "R3"); rd(8'h40, "R3"); rd(8'h44, "R3");
        // word 8 readable under visible policy (R6)
        wr(8'h30, 32'hCAFE_F00D, "R6"); rd(8'h30, "R6");
        // checksum: matching, then mismatching (R8)
        wr(8'h0C, ref_crc(), "R8"); rd(8'h00, "R8");
        wr(8'h0C, ref_crc() ^ 32'h1, "R8"); rd(8'h00, "R8");
        // wipe leaves visible word 8; all-zero lower key gives checksum 0 (R4, R6)
        wr(8'h04, 32'h1, "R4"); rd(8'h00, "R4"); rd(8'h30, "R6");
        wr(8'h0C, 32'h0, "R4"); rd(8'h00, "R4");
        // nonzero word-8 write does not clear the wiped flag here (R5)
        wr(8'h30, 32'h1234_5678, "R5"); rd(8'h00, "R5"); rd(8'h30, "R7");
        // lock is set-only and freezes word 8 (R7)
        wr(8'h4C, 32'h1, "R7"); rd(8'h4C, "R7");
        wr(8'h4C, 32'h0, "R7"); rd(8'h4C, "R7");
        wr(8'h30, 32'h0BAD_0BAD, "R7"); rd(8'h30, "R7");
        // bus errors and interrupt (R10, R9)
        rd(8'h48, "R10"); rd(8'h38, "R10");
        wr(8'h34, 32'h1, "R10"); rd(8'h34, "R10");
        rd(8'h48, "R10"); rd(8'h38, "R10");
        wr(8'h40, 32'h1, "R9"); rd(8'h3C, "R9");
        wr(8'h3C, 32'h1, "R9"); rd(8'h3C, "R9");
        wr(8'h44, 32'h1, "R9"); rd(8'h3C, "R9");
        wr(8'h40, 32'h1, "R9");
        wr(8'h38, 32'h0, "R9"); rd(8'h38, "R9");
        wr(8'h38, 32'h1, "R9"); rd(8'h38, "R9");
        wr(8'h02, 32'h5, "R10"); rd(8'hFC, "R10"); rd(8'h38, "R10");
        wr(8'h38, 32'h1, "R9");
        // reset keeps the key, clears the rest (R11, R1)
        do_reset(1'b0);
        rd(8'h30, "R11"); rd(8'h00, "R1"); rd(8'h4C, "R1"); rd(8'h3C, "R1");
        wr(8'h30, 32'h5555_AAAA, "R7"); rd(8'h30, "R7");
        // ---------------- hidden word-8 policy ----------------
        do_reset(1'b1);
        wr(8'h08, MAGIC, "R2"); rd(8'h00, "R2");
        wr(8'h30, 32'h0000_00AB, "R6"); rd(8'h00, "R5"); rd(8'h30, "R6");
        wr(8'h4C, 32'h1, "R6"); rd(8'h4C, "R6");
        for (int i = 0; i < 8; i++) wr(8'(8'h10 + 4 * i), 32'hA5A5_0000 + 32'(i * 17), "R8");
        wr(8'h0C, ref_crc(), "R8"); rd(8'h00, "R8");
        wr(8'h0C, 32'hFFFF_FFFF, "R8"); rd(8'h00, "R8");
        wr(8'h04, 32'h1, "R6"); rd(8'h00, "R6"); rd(8'h30, "R6");
        wr(8'h0C, 32'h0, "R4"); rd(8'h00, "R4");
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule